// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block carries 32-bit words between two processors, each with its own clock and reset. It holds two independent cross-clock FIFOs. Words that side A pushes come out at side B, and words that side B pushes come out at side A. In each direction the words arrive in the order they were pushed. Word pointers cross between the two clock domains in Gray code through two-stage synchronizers. The local status flags therefore lag the far side by a few cycles, but they only ever lag in the safe direction.

Each side has a strobe-style register interface:
- A push strobe with write data.
- A pop strobe, with the head of the receive FIFO shown on the read data port.
- Receive-empty, transmit-full and receive-level flags.
- Sticky error flags.
- An interrupt toward the local processor.

The interrupt is set when the local receive level rises above a programmable threshold while the interrupt is enabled. It is cleared by a write-one-to-clear strobe. Bus wrappers and message framing above the word level sit outside this block.

Top module: `ipm_mailbox`

## Requirements
- R1: Words pushed at side A appear at side B's read data port in push order, and the same holds from B to A.
- R2: The two directions are independent. Traffic in one direction never changes the contents, level or flags of the other direction.
- R3: The transmit-full flag is 1 whenever the FIFO holds DEPTH words. It returns to 0 only after the far side has popped and the pop has crossed the synchronizers.
- R4: A push while transmit-full is 1 is discarded and sets the sticky overflow flag. That flag stays 1 until an error-clear strobe.
- R5: A pop while receive-empty is 1 leaves the FIFO unchanged, shows zero on read data and sets the sticky underflow flag. That flag stays 1 until an error-clear strobe.
- R6: After reset, receive-empty is 1, transmit-full is 0, and the level, error flags and interrupt are 0. Receive-empty is never 0 while the FIFO holds no word.
- R7: The receive level gives the number of words visible to the reader. The interrupt is set one clock after a cycle in which the interrupt enable is 1 and the level is greater than the threshold. It is never set while the enable is 0.
- R8: An interrupt-clear strobe, given in a cycle where the set condition of R7 is false, drives the interrupt to 0 on the next clock.
- R9: Once set, the interrupt stays 1 after the level falls to or below the threshold, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Side A clock |
| a_rst_n | input | 1 | Side A active-low reset |
| a_push | input | 1 | Push a_wdata toward side B |
| a_wdata | input | 32 | Word to send to side B |
| a_pop | input | 1 | Pop the head of A's receive FIFO |
| a_rdata | output | 32 | Head of A's receive FIFO, zero when empty |
| a_thresh | input | $clog2(DEPTH)+1 | A's receive-level interrupt threshold |
| a_irq_en | input | 1 | A's interrupt enable |
| a_irq_clr | input | 1 | Write-one-to-clear strobe for A's interrupt |
| a_err_clr | input | 1 | Clear strobe for A's sticky error flags |
| a_tx_full | output | 1 | FIFO toward B is full (A's view) |
| a_rx_empty | output | 1 | A's receive FIFO is empty (A's view) |
| a_rx_level | output | $clog2(DEPTH)+1 | Words visible to A |
| a_ovf_err | output | 1 | Sticky: A pushed while full |
| a_udf_err | output | 1 | Sticky: A popped while empty |
| a_irq | output | 1 | Interrupt toward processor A |
| b_clk | input | 1 | Side B clock |
| b_rst_n | input | 1 | Side B active-low reset |
| b_push | input | 1 | Push b_wdata toward side A |
| b_wdata | input | 32 | Word to send to side A |
| b_pop | input | 1 | Pop the head of B's receive FIFO |
| b_rdata | output | 32 | Head of B's receive FIFO, zero when empty |
| b_thresh | input | $clog2(DEPTH)+1 | B's receive-level interrupt threshold |
| b_irq_en | input | 1 | B's interrupt enable |
| b_irq_clr | input | 1 | Write-one-to-clear strobe for B's interrupt |
| b_err_clr | input | 1 | Clear strobe for B's sticky error flags |
| b_tx_full | output | 1 | FIFO toward A is full (B's view) |
| b_rx_empty | output | 1 | B's receive FIFO is empty (B's view) |
| b_rx_level | output | $clog2(DEPTH)+1 | Words visible to B |
| b_ovf_err | output | 1 | Sticky: B pushed while full |
| b_udf_err | output | 1 | Sticky: B popped while empty |
| b_irq | output | 1 | Interrupt toward processor B |

## Verification
The bench builds the mailbox with DEPTH = 4, the smallest depth the Gray full test supports. A four-word burst therefore reaches the full boundary, the dropped fifth push and the level-above-threshold interrupt within a few cycles. The two sides run on unrelated clock periods (5 ns and 7 ns), so each pointer crosses a synchronizer whose phase to the other clock keeps drifting. The checks rely only on FIFO order, on settled values of level and flags after the synchronizers, and on the one-clock timing of the interrupt and error registers.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Per-side sticky state
    typedef struct packed {
        logic ovf;
        logic udf;
        logic irq;
    } side_st_t;
endpackage

// File: rtl/ipm_xfifo.sv
module ipm_xfifo
    import ipm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                      wclk,
    input  logic                      wrst_n,
    input  logic                      push,
    input  word_t                     wdata,
    output logic                      full,
    input  logic                      rclk,
    input  logic                      rrst_n,
    input  logic                      pop,
    output word_t                     head,
    output logic                      empty,
    output logic [$clog2(DEPTH):0]    level
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] s1;   // first sync stage of far gray pointer
        logic [PW-1:0] s2;   // second sync stage
    } ptr_t;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    word_t mem [DEPTH];
    ptr_t  wr_d, wr_q, rd_d, rd_q;
    logic [PW-1:0] wnext, rnext;

    // Full when write gray differs from synced read gray only in the two MSBs
    assign full  = (wr_q.gray == {~wr_q.s2[PW-1:PW-2], wr_q.s2[PW-3:0]});
    assign empty = (rd_q.gray == rd_q.s2);
    assign level = g2b(rd_q.s2) - rd_q.bin;
    assign head  = mem[rd_q.bin[AW-1:0]];

    always_comb begin
        wr_d    = wr_q;
        wr_d.s1 = rd_q.gray;
        wr_d.s2 = wr_q.s1;
        wnext   = wr_q.bin + 1'b1;
        if (push && !full) begin
            wr_d.bin  = wnext;
            wr_d.gray = wnext ^ (wnext >> 1);
        end
    end

    always_comb begin
        rd_d    = rd_q;
        rd_d.s1 = wr_q.gray;
        rd_d.s2 = rd_q.s1;
        rnext   = rd_q.bin + 1'b1;
        if (pop && !empty) begin
            rd_d.bin  = rnext;
            rd_d.gray = rnext ^ (rnext >> 1);
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) wr_q <= '0;
        else         wr_q <= wr_d;
    end

    always_ff @(posedge wclk) begin
        if (push && !full) mem[wr_q.bin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    // Writer's conservative occupancy never exceeds the depth
    logic [PW-1:0] wr_occ;
    assign wr_occ = wr_q.bin - g2b(wr_q.s2);

    assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
        (push && full) |=> (wr_q.bin == $past(wr_q.bin)));

    assert_occ_bound_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_occ <= PW'(DEPTH)));

    assert_no_underflow_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
        (pop && empty) |=> (rd_q.bin == $past(rd_q.bin)));

    assert_level_bound_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        (level <= PW'(DEPTH)) && (empty == (level == '0)));
endmodule

// File: rtl/ipm_side.sv
module ipm_side
    import ipm_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          tx_full,
    input  logic          pop,
    input  logic          rx_empty,
    input  logic [PW-1:0] rx_level,
    input  logic [PW-1:0] thresh,
    input  logic          irq_en,
    input  logic          irq_clr,
    input  logic          err_clr,
    output logic          ovf,
    output logic          udf,
    output logic          irq
);
    side_st_t st_d, st_q;
    logic     hit;

    assign hit = irq_en && (rx_level > thresh);

    always_comb begin
        st_d = st_q;
        if (err_clr) begin
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end
        if (push && tx_full)  st_d.ovf = 1'b1;
        if (pop && rx_empty)  st_d.udf = 1'b1;
        if (irq_clr)          st_d.irq = 1'b0;
        if (hit)              st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf = st_q.ovf;
    assign udf = st_q.udf;
    assign irq = st_q.irq;

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !err_clr) |=> st_q.ovf);

    assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.udf && !err_clr) |=> st_q.udf);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(irq_en && (rx_level > thresh)));

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !hit) |=> !st_q.irq);

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_clr) |=> st_q.irq);
endmodule

// File: rtl/ipm_mailbox.sv
module ipm_mailbox
    import ipm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input  logic          a_clk,
    input  logic          a_rst_n,
    input  logic          a_push,
    input  logic [31:0]   a_wdata,
    input  logic          a_pop,
    output logic [31:0]   a_rdata,
    input  logic [PW-1:0] a_thresh,
    input  logic          a_irq_en,
    input  logic          a_irq_clr,
    input  logic          a_err_clr,
    output logic          a_tx_full,
    output logic          a_rx_empty,
    output logic [PW-1:0] a_rx_level,
    output logic          a_ovf_err,
    output logic          a_udf_err,
    output logic          a_irq,
    input  logic          b_clk,
    input  logic          b_rst_n,
    input  logic          b_push,
    input  logic [31:0]   b_wdata,
    input  logic          b_pop,
    output logic [31:0]   b_rdata,
    input  logic [PW-1:0] b_thresh,
    input  logic          b_irq_en,
    input  logic          b_irq_clr,
    input  logic          b_err_clr,
    output logic          b_tx_full,
    output logic          b_rx_empty,
    output logic [PW-1:0] b_rx_level,
    output logic          b_ovf_err,
    output logic          b_udf_err,
    output logic          b_irq
);
    word_t a_head, b_head;

    ipm_xfifo #(.DEPTH(DEPTH)) u_a2b (
        .wclk(a_clk), .wrst_n(a_rst_n), .push(a_push), .wdata(a_wdata), .full(a_tx_full),
        .rclk(b_clk), .rrst_n(b_rst_n), .pop(b_pop), .head(b_head), .empty(b_rx_empty),
        .level(b_rx_level)
    );

    ipm_xfifo #(.DEPTH(DEPTH)) u_b2a (
        .wclk(b_clk), .wrst_n(b_rst_n), .push(b_push), .wdata(b_wdata), .full(b_tx_full),
        .rclk(a_clk), .rrst_n(a_rst_n), .pop(a_pop), .head(a_head), .empty(a_rx_empty),
        .level(a_rx_level)
    );

    assign a_rdata = a_rx_empty ? '0 : a_head;
    assign b_rdata = b_rx_empty ? '0 : b_head;

    ipm_side #(.PW(PW)) u_side_a (
        .clk(a_clk), .rst_n(a_rst_n), .push(a_push), .tx_full(a_tx_full), .pop(a_pop),
        .rx_empty(a_rx_empty), .rx_level(a_rx_level), .thresh(a_thresh), .irq_en(a_irq_en),
        .irq_clr(a_irq_clr), .err_clr(a_err_clr), .ovf(a_ovf_err), .udf(a_udf_err), .irq(a_irq)
    );

    ipm_side #(.PW(PW)) u_side_b (
        .clk(b_clk), .rst_n(b_rst_n), .push(b_push), .tx_full(b_tx_full), .pop(b_pop),
        .rx_empty(b_rx_empty), .rx_level(b_rx_level), .thresh(b_thresh), .irq_en(b_irq_en),
        .irq_clr(b_irq_clr), .err_clr(b_err_clr), .ovf(b_ovf_err), .udf(b_udf_err), .irq(b_irq)
    );

    assert_empty_rdata_R5: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_rx_empty |-> (b_rdata == '0));
endmodule

// File: tb/ipm_mailbox_tb_top.sv
module ipm_mailbox_tb_top;
    localparam int DEPTH = 4;
    localparam int PW = $clog2(DEPTH) + 1;

    // {direction (0: A->B, 1: B->A), word}; the expected word at the reader is the same word
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 32'hDEAD_BEEF}, {1'b1, 32'h0000_0001}, {1'b0, 32'h1234_5678},
        {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'hA5A5_5A5A}, {1'b1, 32'h0000_0000},
        {1'b0, 32'h8000_0000}, {1'b1, 32'h7FFF_FFFE}
    };

    logic a_clk = 0, b_clk = 0;
    always #2.5 a_clk = ~a_clk;
    always #3.5 b_clk = ~b_clk;

    logic a_rst_n = 0, b_rst_n = 0;
    logic a_push = 0, a_pop = 0, a_irq_en = 0, a_irq_clr = 0, a_err_clr = 0;
    logic b_push = 0, b_pop = 0, b_irq_en = 0, b_irq_clr = 0, b_err_clr = 0;
    logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
    logic [PW-1:0] a_thresh = '0, b_thresh = '0, a_rx_level, b_rx_level;
    logic a_tx_full, a_rx_empty, a_ovf_err, a_udf_err, a_irq;
    logic b_tx_full, b_rx_empty, b_ovf_err, b_udf_err, b_irq;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    ipm_mailbox #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_send(input logic [31:0] d);
        @(negedge a_clk); a_push = 1; a_wdata = d;
        @(negedge a_clk); a_push = 0;
    endtask

    task automatic b_send(input logic [31:0] d);
        @(negedge b_clk); b_push = 1; b_wdata = d;
        @(negedge b_clk); b_push = 0;
    endtask

    task automatic b_take(input logic [31:0] exp, input string req);
        int t = 0;
        @(negedge b_clk);
        while (b_rx_empty && t < 20) begin @(negedge b_clk); t++; end
        check(b_rdata == exp, req, b_rdata, exp);
        b_pop = 1;
        @(negedge b_clk); b_pop = 0;
    endtask

    task automatic a_take(input logic [31:0] exp, input string req);
        int t = 0;
        @(negedge a_clk);
        while (a_rx_empty && t < 20) begin @(negedge a_clk); t++; end
        check(a_rdata == exp, req, a_rdata, exp);
        a_pop = 1;
        @(negedge a_clk); a_pop = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge b_clk);
        a_rst_n = 1; b_rst_n = 1;
        @(negedge a_clk);
        // R6 reset state
        check(a_rx_empty && b_rx_empty, "R6 empty after reset", {a_rx_empty, b_rx_empty}, 2'b11);
        check(!a_tx_full && !b_tx_full, "R6 not full after reset", {a_tx_full, b_tx_full}, 0);
        check({a_irq, b_irq, a_ovf_err, a_udf_err, b_ovf_err, b_udf_err} == 0,
              "R6 flags clear after reset", {a_irq, b_irq, a_ovf_err, a_udf_err, b_ovf_err, b_udf_err}, 0);
        check(a_rx_level == 0 && b_rx_level == 0, "R6 level zero", {a_rx_level, b_rx_level}, 0);

        // R1/R2 table walk: mixed directions
        for (int i = 0; i < 8; i++) begin
            if (!VEC[i][32]) begin a_send(VEC[i][31:0]); b_take(VEC[i][31:0], "R1 A->B order"); end
            else begin b_send(VEC[i][31:0]); a_take(VEC[i][31:0], "R2 B->A path"); end
        end
        repeat (6) @(negedge a_clk);
        check(a_rx_empty && b_rx_empty, "R2 both empty after table", {a_rx_empty, b_rx_empty}, 2'b11);

        // Burst to full, B interrupt at threshold 2
        b_thresh = 2; b_irq_en = 1;
        for (int i = 0; i < DEPTH; i++) a_send(32'h100 + i);
        check(a_tx_full, "R3 full after DEPTH pushes", a_tx_full, 1);
        check(!a_ovf_err, "R4 no overflow yet", a_ovf_err, 0);
        a_send(32'hBAD0_BAD0);
        check(a_ovf_err, "R4 overflow flag set", a_ovf_err, 1);
        repeat (6) @(negedge b_clk);
        check(b_rx_level == PW'(DEPTH), "R7 level equals DEPTH", b_rx_level, DEPTH);
        check(b_irq, "R7 irq above threshold", b_irq, 1);
        check(a_rx_level == 0, "R2 other direction untouched", a_rx_level, 0);
        for (int i = 0; i < DEPTH; i++) b_take(32'h100 + i, "R1 burst order, R4 dropped word absent");
        check(b_irq, "R9 irq held after drain", b_irq, 1);
        // pop while empty
        @(negedge b_clk);
        check(b_rdata == 0, "R5 empty read returns zero", b_rdata, 0);
        b_pop = 1;
        @(negedge b_clk); b_pop = 0;
        check(b_udf_err, "R5 underflow flag set", b_udf_err, 1);
        check(b_rx_empty, "R5 fifo still empty", b_rx_empty, 1);
        b_irq_clr = 1;
        @(negedge b_clk); b_irq_clr = 0;
        check(!b_irq, "R8 irq cleared", b_irq, 0);
        check(b_udf_err, "R5 underflow sticky", b_udf_err, 1);
        b_err_clr = 1;
        @(negedge b_clk); b_err_clr = 0;
        check(!b_udf_err, "R5 underflow cleared", b_udf_err, 0);
        check(a_ovf_err, "R4 overflow sticky", a_ovf_err, 1);
        a_err_clr = 1;
        @(negedge a_clk); a_err_clr = 0;
        check(!a_ovf_err, "R4 overflow cleared", a_ovf_err, 0);
        repeat (5) @(negedge a_clk);
        check(!a_tx_full, "R3 full released after drain", a_tx_full, 0);

        // R7 enable gating on side A
        a_thresh = 0; a_irq_en = 0;
        b_send(32'hCAFE_0001);
        repeat (6) @(negedge a_clk);
        check(a_rx_level == 1, "R7 level one", a_rx_level, 1);
        check(!a_irq, "R7 irq blocked while disabled", a_irq, 0);
        a_irq_en = 1;
        @(negedge a_clk);
        check(a_irq, "R7 irq one clock after enable", a_irq, 1);
        a_take(32'hCAFE_0001, "R1 single word B->A");
        a_irq_clr = 1;
        @(negedge a_clk); a_irq_clr = 0;
        check(!a_irq, "R8 irq cleared on side A", a_irq, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule